// File: doc/BRIEF.md
# Sleep entry and wakeup controller

This block decides when a processor core may stop and when it must resume. Software can ask for sleep in three ways: a wait-for-interrupt request, a wait-for-event request, or the return from an interrupt handler while a sleep-on-exit setting is on. The block records which kind of wait was used. That record sets the wake rule. Waits of the interrupt kind end when an enabled interrupt is pending. Waits of the event kind end on an event.

Interrupt requests are turned into per-line pending bits. A pending bit is set on the rising edge of its request and cleared by a write-one-to-clear strobe. Event-mode lines never touch these bits. An optional setting lets a disabled interrupt that becomes pending count as an event. A one-bit event latch holds any event that arrives when no event-kind wait can consume it. The next wait-for-event request then returns at once and does not sleep. The outputs are a sleeping flag, a one-cycle wake pulse, the stored entry kind and the pending bits. All inputs are synchronous to the block clock.

Top module: `slpwk_ctrl`

## Requirements
- R1: After reset: sleeping is 0, wake_pulse is 0, entry_mode is 00, irq_pending is all zero, and the event latch is clear, so the first wait-for-event request puts the core to sleep.
- R2: A 0-to-1 change of irq_req[i] sets irq_pending[i] on the next clock edge. irq_clr[i] clears the bit. A request held high does not set the bit again. When a rising edge and a clear come in the same cycle, the set wins.
- R3: A wfi_req with no enabled pending interrupt and a clear event latch makes sleeping 1 and entry_mode 01 (interrupt kind) at the next edge.
- R4: A wfi_req or wfe_req is ignored while any enabled interrupt is pending, and the core stays running. A wfi_req is also ignored while the event latch is set.
- R5: hret_strobe with sleep_on_exit at 1 enters sleep with entry_mode 01. With sleep_on_exit at 0, the strobe has no effect.
- R6: In interrupt-kind sleep, the wake happens at the edge after an enabled pending bit is seen. So it comes two edges after the rising edge of irq_req. At that edge sleeping goes to 0, entry_mode to 00 and wake_pulse to 1. Event lines and disabled pending bits do not wake this kind of sleep.
- R7: A wfe_req enters sleep with entry_mode 10 (event kind). Any evt_line bit that is high wakes the core at the next edge.
- R8: When pend_to_evt is 1, the rising edge of a disabled irq_req wakes event-kind sleep at the next edge, and its pending bit stays set. When pend_to_evt is 0, the same edge does not wake the core.
- R9: evt_line activity never sets any irq_pending bit.
- R10: An event that is not consumed by an event-kind wake sets the event latch. This includes an event during interrupt-kind sleep. The next wfe_req clears the latch and the core stays running. The following wfe_req sleeps.
- R11: When requests arrive together, wfe_req has priority over wfi_req, and wfi_req has priority over sleep-on-exit.
- R12: wake_pulse is high for exactly one cycle, and only at the edge where sleeping falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfe_req | input | 1 | Wait-for-event request |
| hret_strobe | input | 1 | Return-from-handler strobe |
| sleep_on_exit | input | 1 | Sleep on handler return when set |
| pend_to_evt | input | 1 | Disabled interrupt becoming pending counts as event |
| irq_req | input | N_IRQ | Peripheral interrupt request levels |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| irq_clr | input | N_IRQ | Per-line write-one-to-clear of pending bits |
| evt_line | input | N_EVL | Event-mode line inputs |
| sleeping | output | 1 | Core is asleep |
| wake_pulse | output | 1 | One-cycle wake indication |
| entry_mode | output | 2 | 00 running, 01 interrupt kind, 10 event kind |
| irq_pending | output | N_IRQ | Pending bits |

## Verification
Sleep entry, the pending set and clear, and an event-line wake all show up one edge after the inputs that cause them. An interrupt wake shows up two edges after the rising edge of the request, because the pending bit has to be registered first. The bench drives inputs 1 ns after a rising edge and reads outputs at that same point after the following edge. Each directed check therefore lands on the edge where the requirement says the result is due. A cycle-level model built from the requirements also predicts every output after each edge during the random phase.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_EVT  = 2'b10
    } slp_mode_e;

    typedef struct packed {
        logic wfe;
        logic wfi;
        logic hret_soe;
    } entry_req_t;

    typedef struct packed {
        logic      slp;
        slp_mode_e mode;
        logic      latch;
        logic      wake;
    } core_state_t;

    localparam core_state_t CORE_RESET = '{slp: 1'b0, mode: MODE_NONE,
                                           latch: 1'b0, wake: 1'b0};

endpackage

// File: rtl/slpwk_pend.sv
module slpwk_pend #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] clr,
    output logic [N_IRQ-1:0] rise,
    output logic [N_IRQ-1:0] pend
);
    logic [N_IRQ-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req;
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign rise[i] = req[i] & ~req_q[i];
        always_ff @(posedge clk) begin
            if (rst)          pend[i] <= 1'b0;
            else if (rise[i]) pend[i] <= 1'b1;   // set beats clear
            else if (clr[i])  pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/slpwk_evsrc.sv
module slpwk_evsrc #(
    parameter int N_IRQ = 8,
    parameter int N_EVL = 4
) (
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] rise,
    input  logic [N_IRQ-1:0] en,
    input  logic [N_EVL-1:0] evt_line,
    input  logic             pend_to_evt,
    output logic             irq_ready,
    output logic             evt_now
);
    logic from_irq;

    assign irq_ready = |(pend & en);
    assign from_irq  = pend_to_evt & (|(rise & ~en));
    assign evt_now   = (|evt_line) | from_irq;
endmodule

// File: rtl/slpwk_core.sv
module slpwk_core
    import slpwk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  entry_req_t  req,
    input  logic        irq_ready,
    input  logic        evt_now,
    output core_state_t st
);
    core_state_t nx;

    always_comb begin
        nx      = st;
        nx.wake = 1'b0;
        if (!st.slp) begin
            if (req.wfe) begin
                if (st.latch || evt_now) begin
                    nx.latch = 1'b0;                 // consume, stay running
                end else if (!irq_ready) begin
                    nx.slp  = 1'b1;
                    nx.mode = MODE_EVT;
                end
            end else begin
                if (req.wfi) begin
                    if (!irq_ready && !st.latch) begin
                        nx.slp  = 1'b1;
                        nx.mode = MODE_IRQ;
                    end
                end else if (req.hret_soe) begin
                    nx.slp  = 1'b1;
                    nx.mode = MODE_IRQ;
                end
                if (evt_now) nx.latch = 1'b1;
            end
        end else if (st.mode == MODE_IRQ) begin
            if (irq_ready) begin
                nx.slp  = 1'b0;
                nx.mode = MODE_NONE;
                nx.wake = 1'b1;
            end
            if (evt_now) nx.latch = 1'b1;
        end else begin
            if (evt_now) begin
                nx.slp  = 1'b0;
                nx.mode = MODE_NONE;
                nx.wake = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= CORE_RESET;
        else     st <= nx;
    end
endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
    import slpwk_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_EVL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             hret_strobe,
    input  logic             sleep_on_exit,
    input  logic             pend_to_evt,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_clr,
    input  logic [N_EVL-1:0] evt_line,
    output logic             sleeping,
    output logic             wake_pulse,
    output logic [1:0]       entry_mode,
    output logic [N_IRQ-1:0] irq_pending
);
    logic [N_IRQ-1:0] rise;
    logic             irq_ready;
    logic             evt_now;
    entry_req_t       req;
    core_state_t      st;

    assign req.wfe      = wfe_req;
    assign req.wfi      = wfi_req;
    assign req.hret_soe = hret_strobe & sleep_on_exit;

    slpwk_pend #(.N_IRQ(N_IRQ)) u_pend (
        .clk(clk), .rst(rst), .req(irq_req), .clr(irq_clr),
        .rise(rise), .pend(irq_pending)
    );

    slpwk_evsrc #(.N_IRQ(N_IRQ), .N_EVL(N_EVL)) u_evsrc (
        .pend(irq_pending), .rise(rise), .en(irq_en), .evt_line(evt_line),
        .pend_to_evt(pend_to_evt), .irq_ready(irq_ready), .evt_now(evt_now)
    );

    slpwk_core u_core (
        .clk(clk), .rst(rst), .req(req), .irq_ready(irq_ready),
        .evt_now(evt_now), .st(st)
    );

    assign sleeping   = st.slp;
    assign wake_pulse = st.wake;
    assign entry_mode = st.mode;
endmodule

// File: rtl/slpwk_ctrl_chk.sv
module slpwk_ctrl_chk #(
    parameter int N_IRQ = 8,
    parameter int N_EVL = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wfi_req,
    input logic             wfe_req,
    input logic             hret_strobe,
    input logic             sleep_on_exit,
    input logic             pend_to_evt,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic [N_IRQ-1:0] irq_clr,
    input logic [N_EVL-1:0] evt_line,
    input logic             sleeping,
    input logic             wake_pulse,
    input logic [1:0]       entry_mode,
    input logic [N_IRQ-1:0] irq_pending
);
    p_pulse_single_r12: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    p_pulse_on_fall_r12: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (!sleeping && $past(sleeping)));

    p_mode_tracks_r3: assert property (@(posedge clk) disable iff (rst)
        sleeping == (entry_mode != 2'b00));

    p_irq_wake_r6: assert property (@(posedge clk) disable iff (rst)
        (sleeping && entry_mode == 2'b01 && |(irq_pending & irq_en))
        |=> (wake_pulse && !sleeping));

    p_evt_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (sleeping && entry_mode == 2'b10 && evt_line != '0)
        |=> (wake_pulse && entry_mode == 2'b00));

    p_pend_needs_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_pending & ~$past(irq_pending) & ~$past(irq_req)) == '0);

    p_ignored_when_pending_r4: assert property (@(posedge clk) disable iff (rst)
        (!sleeping && |(irq_pending & irq_en) && (wfi_req || wfe_req))
        |=> !sleeping);
endmodule

bind slpwk_ctrl slpwk_ctrl_chk #(.N_IRQ(N_IRQ), .N_EVL(N_EVL)) u_chk (.*);

// File: tb/slpwk_ctrl_bench.sv
`timescale 1ns/1ps
module slpwk_ctrl_bench;
    localparam int NI = 8;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wfi_req = 0, wfe_req = 0, hret_strobe = 0;
    logic          sleep_on_exit = 0, pend_to_evt = 0;
    logic [NI-1:0] irq_req = '0, irq_en = '0, irq_clr = '0;
    logic [NE-1:0] evt_line = '0;
    logic          sleeping, wake_pulse;
    logic [1:0]    entry_mode;
    logic [NI-1:0] irq_pending;

    slpwk_ctrl #(.N_IRQ(NI), .N_EVL(NE)) u_slpwk_ctrl (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .hret_strobe(hret_strobe), .sleep_on_exit(sleep_on_exit),
        .pend_to_evt(pend_to_evt), .irq_req(irq_req), .irq_en(irq_en),
        .irq_clr(irq_clr), .evt_line(evt_line), .sleeping(sleeping),
        .wake_pulse(wake_pulse), .entry_mode(entry_mode),
        .irq_pending(irq_pending)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state, written from the requirements
    logic          m_slp = 0, m_wake = 0, m_latch = 0;
    logic [1:0]    m_mode = 0;
    logic [NI-1:0] m_pend = '0, m_q = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic ev_of(input logic [NI-1:0] rise);
        return (|evt_line) | (pend_to_evt & (|(rise & ~irq_en)));
    endfunction

    task automatic tick();
        logic [NI-1:0] rise, pn;
        logic ipen, evn, s, w, l;
        logic [1:0] md;
        rise = irq_req & ~m_q;
        pn   = (m_pend & ~irq_clr) | rise;
        ipen = |(m_pend & irq_en);
        evn  = ev_of(rise);
        s = m_slp; md = m_mode; l = m_latch; w = 1'b0;
        if (!m_slp) begin
            if (wfe_req) begin
                if (m_latch || evn) l = 1'b0;
                else if (!ipen) begin s = 1'b1; md = 2'b10; end
            end else begin
                if (wfi_req) begin
                    if (!ipen && !m_latch) begin s = 1'b1; md = 2'b01; end
                end else if (hret_strobe && sleep_on_exit) begin
                    s = 1'b1; md = 2'b01;
                end
                if (evn) l = 1'b1;
            end
        end else if (m_mode == 2'b01) begin
            if (ipen) begin s = 1'b0; md = 2'b00; w = 1'b1; end
            if (evn) l = 1'b1;
        end else if (evn) begin
            s = 1'b0; md = 2'b00; w = 1'b1;
        end
        @(posedge clk);
        #1;
        if (rst) begin
            m_slp = 0; m_mode = 0; m_latch = 0; m_wake = 0; m_pend = '0; m_q = '0;
        end else begin
            m_slp = s; m_mode = md; m_latch = l; m_wake = w; m_pend = pn; m_q = irq_req;
        end
        chk("R3 model sleeping", 32'(sleeping), 32'(m_slp));
        chk("R3 model entry_mode", 32'(entry_mode), 32'(m_mode));
        chk("R12 model wake_pulse", 32'(wake_pulse), 32'(m_wake));
        chk("R2 model irq_pending", 32'(irq_pending), 32'(m_pend));
    endtask

    task automatic idle();
        wfi_req = 0; wfe_req = 0; hret_strobe = 0; irq_clr = '0; evt_line = '0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(); tick();
        rst = 0;
        tick();
        // R1
        chk("R1 sleeping", 32'(sleeping), 0);
        chk("R1 wake_pulse", 32'(wake_pulse), 0);
        chk("R1 entry_mode", 32'(entry_mode), 0);
        chk("R1 irq_pending", 32'(irq_pending), 0);

        // R2 pending set/clear/level/collision
        irq_req[2] = 1; tick();
        chk("R2 set on edge", 32'(irq_pending[2]), 1);
        irq_clr[2] = 1; tick(); irq_clr[2] = 0;
        chk("R2 clear", 32'(irq_pending[2]), 0);
        tick();
        chk("R2 held level no reset", 32'(irq_pending[2]), 0);
        irq_req[2] = 0; irq_req[3] = 1; irq_clr[3] = 1; tick();
        chk("R2 set wins", 32'(irq_pending[3]), 1);
        irq_clr[3] = 1; irq_req[3] = 0; tick(); irq_clr = '0;

        // R3 / R6 / R10
        irq_en = '1;
        wfi_req = 1; tick(); wfi_req = 0;
        chk("R3 sleeping", 32'(sleeping), 1);
        chk("R3 mode irq", 32'(entry_mode), 1);
        evt_line[0] = 1; tick(); evt_line = '0;
        chk("R6 event no wake", 32'(sleeping), 1);
        irq_req[0] = 1; tick(); irq_req[0] = 0;
        chk("R6 not yet", 32'(sleeping), 1);
        tick();
        chk("R6 woke", 32'(sleeping), 0);
        chk("R6 wake pulse", 32'(wake_pulse), 1);
        chk("R6 mode cleared", 32'(entry_mode), 0);
        irq_clr[0] = 1; tick(); irq_clr = '0;
        chk("R12 pulse one cycle", 32'(wake_pulse), 0);
        wfi_req = 1; tick(); wfi_req = 0;
        chk("R4 wfi ignored, latch set", 32'(sleeping), 0);
        wfe_req = 1; tick();
        chk("R10 wfe consumes latch", 32'(sleeping), 0);
        tick(); wfe_req = 0;
        chk("R10 second wfe sleeps", 32'(sleeping), 1);
        chk("R7 mode evt", 32'(entry_mode), 2);

        // R7 / R9
        evt_line[1] = 1; tick(); evt_line = '0;
        chk("R7 event wake", 32'(wake_pulse), 1);
        chk("R7 awake", 32'(sleeping), 0);
        chk("R9 no pending from event", 32'(irq_pending), 0);
        tick();

        // R4
        irq_req[5] = 1; tick();
        wfi_req = 1; tick(); wfi_req = 0;
        chk("R4 wfi ignored", 32'(sleeping), 0);
        wfe_req = 1; tick(); wfe_req = 0;
        chk("R4 wfe ignored", 32'(sleeping), 0);
        irq_req[5] = 0; irq_clr[5] = 1; tick(); irq_clr = '0;

        // R5
        hret_strobe = 1; tick();
        chk("R5 no soe no sleep", 32'(sleeping), 0);
        sleep_on_exit = 1; tick(); hret_strobe = 0; sleep_on_exit = 0;
        chk("R5 soe sleep", 32'(sleeping), 1);
        chk("R5 soe mode", 32'(entry_mode), 1);
        irq_req[1] = 1; tick(); irq_req[1] = 0; tick();
        chk("R5 soe irq wake", 32'(wake_pulse), 1);
        irq_clr[1] = 1; tick(); irq_clr = '0;

        // R8
        irq_en = 8'hF0; pend_to_evt = 1;
        wfe_req = 1; tick(); wfe_req = 0;
        chk("R8 sleeping", 32'(sleeping), 1);
        irq_req[0] = 1; tick(); irq_req[0] = 0;
        chk("R8 disabled irq wakes", 32'(wake_pulse), 1);
        chk("R8 pending kept", 32'(irq_pending[0]), 1);
        irq_clr[0] = 1; tick(); irq_clr = '0;
        pend_to_evt = 0;
        wfe_req = 1; tick(); wfe_req = 0;
        irq_req[0] = 1; tick(); irq_req[0] = 0;
        chk("R8 option off no wake", 32'(sleeping), 1);
        evt_line[2] = 1; tick(); evt_line = '0;
        chk("R8 then event wakes", 32'(sleeping), 0);
        irq_clr[0] = 1; tick(); irq_clr = '0;

        // R11
        irq_en = '1;
        wfi_req = 1; wfe_req = 1; hret_strobe = 1; sleep_on_exit = 1; tick(); idle();
        chk("R11 wfe wins", 32'(entry_mode), 2);
        evt_line[3] = 1; tick(); evt_line = '0;
        wfi_req = 1; hret_strobe = 1; tick(); idle();
        chk("R11 wfi over exit", 32'(entry_mode), 1);
        irq_req[6] = 1; tick(); irq_req[6] = 0; tick();
        chk("R11 woke", 32'(sleeping), 0);
        irq_clr[6] = 1; tick(); irq_clr = '0; sleep_on_exit = 0;

        // random phase, checked by the model in tick()
        for (int k = 0; k < 4000; k++) begin
            wfi_req       = ($urandom % 8) == 0;
            wfe_req       = ($urandom % 8) == 0;
            hret_strobe   = ($urandom % 8) == 0;
            sleep_on_exit = $urandom % 2;
            if (($urandom % 4) == 0) irq_req = irq_req ^ NI'(1 << ($urandom % NI));
            irq_clr = (($urandom % 3) == 0) ? NI'($urandom) : '0;
            evt_line = (($urandom % 12) == 0) ? NE'(1 << ($urandom % NE)) : '0;
            if (($urandom % 64) == 0) irq_en = NI'($urandom);
            if (($urandom % 64) == 0) pend_to_evt = $urandom % 2;
            tick();
        end
        idle();
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule